// File: doc/BRIEF.md
# SMBus Host Command Sequencer

This block is the host-side register file and transfer sequencer of an SMBus master. Software, or a local controller, programs a target address, a command code and up to two data bytes through a byte-wide register port. It then writes the control register with a protocol code and the start bit set. The sequencer breaks the chosen transfer into byte steps and hands each step to a separate byte-level bus engine. That engine owns the SCL/SDA timing. It reports back per byte whether the target acknowledged, whether arbitration was lost, and which byte it received.

Completion and faults are latched in a status register whose flags are cleared by writing ones. A kill bit in the control register aborts a transfer in progress and marks it as failed. The supported protocols are quick, send/receive byte, byte-data and word-data. The block data buffer and packet-error checking are outside this block.

Top module: `smbus_host_seq`

## Requirements
- R1: The register port decodes status at offset 0, control at 2, command at 3, address at 4, data0 at 5 and data1 at 6. Offsets 1 and 7 read 0. Control reads back as written except bit 6 (start), which always reads 0.
- R2: A control write with bit 6 set starts a transfer only if all of these hold: status bits 4:0 are all zero, the written kill bit (bit 1) is 0, and the protocol field (bits 4:2) is 0 (quick), 1 (byte), 2 (byte-data) or 3 (word). An accepted start sets status bit 0 (busy) in the cycle after the write. Any other start is ignored: busy stays 0 and no engine step is issued.
- R3: Steps are issued in a fixed order for each protocol:
  - Quick and byte transfers first send the address register unchanged. A byte write then sends the command register; a byte read receives one byte.
  - Byte-data and word transfers send the address with bit 0 forced to 0, then the command. A write then sends data0, and for word also data1. A read sends the address with bit 0 forced to 1, marked as a new start condition, then receives one or two bytes.
  - The address register's bit 0 is the read flag: 1 means read.
- R4: A byte received in the first receive step is stored in data0. A byte received in the second receive step is stored in data1, so a word read holds the low byte in data0 and the high byte in data1.
- R5: When the last step completes without error, busy clears and status bit 1 (done) sets on the same clock edge.
- R6: A not-acknowledged response ends the transfer at once. It clears busy, sets status bit 2 and leaves bit 1 clear. No further step is issued and the data registers are not loaded.
- R7: An arbitration-loss response ends the transfer at once. It clears busy and sets status bit 3.
- R8: While busy, a kill bit held at 1 ends the transfer on the next edge. That edge clears busy and sets status bit 4. The kill bit drives the engine abort output. Engine responses that arrive after the abort change nothing. After the kill bit is written back to 0, a start is accepted again.
- R9: A status write clears each of bits 4:1 where the written bit is 1 and leaves it unchanged where the written bit is 0. Writes to bit 0 have no effect.
- R10: Each step is a one-cycle request pulse, and the next request is not issued before the engine's done pulse. The stop-condition flag is raised only on the final step of the protocol.
- R11: After reset all registers read 0 and no engine request is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 3 | Register offset |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data, combinational from regAddr |
| engGo | output | 1 | One-cycle request for one byte step |
| engTxByte | output | 8 | Byte to send in this step |
| engStartCond | output | 1 | Precede this step with a (repeated) start condition |
| engStopCond | output | 1 | Follow this step with a stop condition |
| engRx | output | 1 | This step receives a byte |
| engKill | output | 1 | Abort request to the engine (level) |
| engDone | input | 1 | One-cycle step completion from the engine |
| engRxByte | input | 8 | Received byte, valid with engDone |
| engNak | input | 1 | Target did not acknowledge, valid with engDone |
| engCollide | input | 1 | Arbitration lost, valid with engDone |

## Verification
A register write takes effect on the edge that samples it. Busy is therefore visible one cycle after the start write, which is where the bench reads status, at the falling edge that follows the write. The first engine request appears in that same cycle, and each later request appears one cycle after the previous done pulse. The bench's engine model answers two cycles after each request, so completion is reached by polling busy. Done, error and data values are read only after busy has fallen. A kill takes two edges: one to store the kill bit and one to end the transfer. The bench reads the failed flag two cycles after the kill write, and again many cycles later to confirm that a late engine response left the registers alone.

// File: rtl/smbus_host_pkg.sv
package smbus_host_pkg;
  localparam int BYTE_W  = 8;
  localparam int REG_AW  = 3;
  localparam int PROTO_W = 2;

  localparam logic [REG_AW-1:0] OFS_STATUS = 3'd0;
  localparam logic [REG_AW-1:0] OFS_CTRL   = 3'd2;
  localparam logic [REG_AW-1:0] OFS_CMD    = 3'd3;
  localparam logic [REG_AW-1:0] OFS_ADDR   = 3'd4;
  localparam logic [REG_AW-1:0] OFS_DAT0   = 3'd5;
  localparam logic [REG_AW-1:0] OFS_DAT1   = 3'd6;

  // control register bit positions
  localparam int CTL_KILL  = 1;
  localparam int CTL_START = 6;

  localparam logic [PROTO_W-1:0] PROTO_QUICK = 2'd0;
  localparam logic [PROTO_W-1:0] PROTO_BYTE  = 2'd1;
  localparam logic [PROTO_W-1:0] PROTO_BDATA = 2'd2;
  localparam logic [PROTO_W-1:0] PROTO_WORD  = 2'd3;

  typedef enum logic [3:0] {
    STEP_ADDR, STEP_ADDRW, STEP_ADDRR, STEP_CMD,
    STEP_TX0, STEP_TX1, STEP_RX0, STEP_RX1, STEP_END
  } step_e;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} seq_e;

  typedef struct packed {
    logic setIntr;
    logic setDevErr;
    logic setCollide;
    logic setFail;
    logic loadD0;
    logic loadD1;
  } strobe_t;
endpackage

// File: rtl/smbus_host_ctrl.sv
module smbus_host_ctrl
  import smbus_host_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               startOk,
  input  logic [PROTO_W-1:0] protoIn,
  input  logic               rwIn,
  input  logic               killReq,
  input  logic               engDone,
  input  logic               engNak,
  input  logic               engCollide,
  output logic               busy,
  output step_e              step,
  output logic               engGo,
  output logic               engStartCond,
  output logic               engStopCond,
  output logic               engRx,
  output strobe_t            strobe
);
  seq_e               state;
  logic [PROTO_W-1:0] protoLat;
  logic               rwLat;
  step_e              stepAfter;
  logic               killHit;
  logic               doneHit;
  logic               cleanDone;

  function automatic step_e nextStep(step_e cur, logic [PROTO_W-1:0] p, logic rd);
    case (cur)
      STEP_ADDR:  nextStep = (p == PROTO_QUICK) ? STEP_END : (rd ? STEP_RX0 : STEP_CMD);
      STEP_ADDRW: nextStep = STEP_CMD;
      STEP_CMD:   nextStep = (p == PROTO_BYTE) ? STEP_END : (rd ? STEP_ADDRR : STEP_TX0);
      STEP_ADDRR: nextStep = STEP_RX0;
      STEP_TX0:   nextStep = (p == PROTO_WORD) ? STEP_TX1 : STEP_END;
      STEP_RX0:   nextStep = (p == PROTO_WORD) ? STEP_RX1 : STEP_END;
      default:    nextStep = STEP_END;
    endcase
  endfunction

  assign stepAfter = nextStep(step, protoLat, rwLat);
  assign killHit   = killReq && busy;
  assign doneHit   = (state == ST_WAIT) && engDone && !killHit;
  assign cleanDone = doneHit && !engNak && !engCollide;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      busy     <= 1'b0;
      step     <= STEP_ADDR;
      protoLat <= PROTO_QUICK;
      rwLat    <= 1'b0;
    end else if (killHit) begin
      state <= ST_IDLE;
      busy  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (startOk) begin
          state    <= ST_ISSUE;
          busy     <= 1'b1;
          protoLat <= protoIn;
          rwLat    <= rwIn;
          step     <= protoIn[1] ? STEP_ADDRW : STEP_ADDR;
        end
        ST_ISSUE: state <= ST_WAIT;
        ST_WAIT: if (engDone) begin
          if (engNak || engCollide || stepAfter == STEP_END) begin
            state <= ST_IDLE;
            busy  <= 1'b0;
          end else begin
            step  <= stepAfter;
            state <= ST_ISSUE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    engGo        = (state == ST_ISSUE);
    engStartCond = (step == STEP_ADDR) || (step == STEP_ADDRW) || (step == STEP_ADDRR);
    engStopCond  = (stepAfter == STEP_END);
    engRx        = (step == STEP_RX0) || (step == STEP_RX1);
    strobe.setFail    = killHit;
    strobe.setDevErr  = doneHit && engNak;
    strobe.setCollide = doneHit && !engNak && engCollide;
    strobe.setIntr    = cleanDone && (stepAfter == STEP_END);
    strobe.loadD0     = cleanDone && (step == STEP_RX0);
    strobe.loadD1     = cleanDone && (step == STEP_RX1);
  end
endmodule

// File: rtl/smbus_host_regs.sv
module smbus_host_regs
  import smbus_host_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               regWr,
  input  logic [REG_AW-1:0]  regAddr,
  input  logic [BYTE_W-1:0]  regWdata,
  output logic [BYTE_W-1:0]  regRdata,
  input  logic               busy,
  input  step_e              step,
  input  strobe_t            strobe,
  input  logic [BYTE_W-1:0]  engRxByte,
  output logic               startOk,
  output logic [PROTO_W-1:0] protoOut,
  output logic               rwOut,
  output logic               killReq,
  output logic [BYTE_W-1:0]  engTxByte,
  output logic [BYTE_W-1:0]  statusVec
);
  logic [BYTE_W-1:0] ctrlReg, cmdReg, addrReg, dat0Reg, dat1Reg;
  logic intrF, devErrF, colF, failF;
  logic stsWr, ctrlWr, stsClean, protoOk;

  assign stsWr    = regWr && (regAddr == OFS_STATUS);
  assign ctrlWr   = regWr && (regAddr == OFS_CTRL);
  assign stsClean = !(busy || intrF || devErrF || colF || failF);
  assign protoOk  = !regWdata[4];
  assign startOk  = ctrlWr && regWdata[CTL_START] && !regWdata[CTL_KILL] && protoOk && stsClean;
  assign protoOut = regWdata[3:2];
  assign rwOut    = addrReg[0];
  assign killReq  = ctrlReg[CTL_KILL];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrlReg <= '0; cmdReg <= '0; addrReg <= '0; dat0Reg <= '0; dat1Reg <= '0;
      intrF <= 1'b0; devErrF <= 1'b0; colF <= 1'b0; failF <= 1'b0;
    end else begin
      if (ctrlWr) ctrlReg <= regWdata & ~(BYTE_W'(1) << CTL_START);
      if (regWr && regAddr == OFS_CMD)  cmdReg  <= regWdata;
      if (regWr && regAddr == OFS_ADDR) addrReg <= regWdata;
      if (strobe.loadD0) dat0Reg <= engRxByte;
      else if (regWr && regAddr == OFS_DAT0) dat0Reg <= regWdata;
      if (strobe.loadD1) dat1Reg <= engRxByte;
      else if (regWr && regAddr == OFS_DAT1) dat1Reg <= regWdata;
      // set has priority over a same-cycle clear
      intrF   <= (intrF   && !(stsWr && regWdata[1])) || strobe.setIntr;
      devErrF <= (devErrF && !(stsWr && regWdata[2])) || strobe.setDevErr;
      colF    <= (colF    && !(stsWr && regWdata[3])) || strobe.setCollide;
      failF   <= (failF   && !(stsWr && regWdata[4])) || strobe.setFail;
    end
  end

  assign statusVec = {3'b000, failF, colF, devErrF, intrF, busy};

  always_comb begin
    case (step)
      STEP_ADDR:  engTxByte = addrReg;
      STEP_ADDRW: engTxByte = {addrReg[BYTE_W-1:1], 1'b0};
      STEP_ADDRR: engTxByte = {addrReg[BYTE_W-1:1], 1'b1};
      STEP_CMD:   engTxByte = cmdReg;
      STEP_TX0:   engTxByte = dat0Reg;
      STEP_TX1:   engTxByte = dat1Reg;
      default:    engTxByte = '0;
    endcase
    case (regAddr)
      OFS_STATUS: regRdata = statusVec;
      OFS_CTRL:   regRdata = ctrlReg;
      OFS_CMD:    regRdata = cmdReg;
      OFS_ADDR:   regRdata = addrReg;
      OFS_DAT0:   regRdata = dat0Reg;
      OFS_DAT1:   regRdata = dat1Reg;
      default:    regRdata = '0;
    endcase
  end
endmodule

// File: rtl/smbus_host_seq.sv
module smbus_host_seq
  import smbus_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWr,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [BYTE_W-1:0] regWdata,
  output logic [BYTE_W-1:0] regRdata,
  output logic              engGo,
  output logic [BYTE_W-1:0] engTxByte,
  output logic              engStartCond,
  output logic              engStopCond,
  output logic              engRx,
  output logic              engKill,
  input  logic              engDone,
  input  logic [BYTE_W-1:0] engRxByte,
  input  logic              engNak,
  input  logic              engCollide
);
  logic               busy, startOk, rwBit, killReq;
  logic [PROTO_W-1:0] protoSel;
  logic [BYTE_W-1:0]  statusVec;
  step_e              step;
  strobe_t            strobe;

  assign engKill = killReq;

  smbus_host_regs u_regs (
    .clk(clk), .rst_n(rst_n), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .busy(busy), .step(step),
    .strobe(strobe), .engRxByte(engRxByte), .startOk(startOk),
    .protoOut(protoSel), .rwOut(rwBit), .killReq(killReq),
    .engTxByte(engTxByte), .statusVec(statusVec)
  );

  smbus_host_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .startOk(startOk), .protoIn(protoSel),
    .rwIn(rwBit), .killReq(killReq), .engDone(engDone), .engNak(engNak),
    .engCollide(engCollide), .busy(busy), .step(step), .engGo(engGo),
    .engStartCond(engStartCond), .engStopCond(engStopCond), .engRx(engRx),
    .strobe(strobe)
  );
endmodule

// File: rtl/smbus_host_chk.sv
module smbus_host_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] statusVec,
  input logic       engGo,
  input logic       engDone,
  input logic       engNak,
  input logic       engKill
);
  // R5: busy only falls together with a done or error flag
  a_r5_fall_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(statusVec[0]) |-> (statusVec[4:1] != 4'b0000));

  // R2: a transfer only begins from a clean status
  a_r2_start_from_clean: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(statusVec[0]) |-> $past(statusVec[4:1] == 4'b0000));

  // R6: a not-acknowledged step ends the transfer without the done flag
  a_r6_nak_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (statusVec[0] && engDone && engNak && !engKill) |=>
      (!statusVec[0] && statusVec[2] && !statusVec[1]));

  // R8: a held kill ends a busy transfer on the next edge
  a_r8_kill_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    (statusVec[0] && engKill) |=> (!statusVec[0] && statusVec[4]));

  // R10: step requests are single-cycle pulses issued only while busy
  a_r10_go_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    engGo |=> !engGo);
  a_r10_go_busy: assert property (@(posedge clk) disable iff (!rst_n)
    engGo |-> statusVec[0]);
endmodule

bind smbus_host_seq smbus_host_chk u_chk (
  .clk(clk), .rst_n(rst_n), .statusVec(statusVec), .engGo(engGo),
  .engDone(engDone), .engNak(engNak), .engKill(engKill)
);

// File: tb/smbus_host_seq_tb.sv
`timescale 1ns/1ps
module smbus_host_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic regWr = 1'b0;
  logic [2:0] regAddr = 3'd0;
  logic [7:0] regWdata = 8'h00;
  logic [7:0] regRdata;
  logic engGo, engStartCond, engStopCond, engRx, engKill;
  logic [7:0] engTxByte;
  logic engDone = 1'b0, engNak = 1'b0, engCollide = 1'b0;
  logic [7:0] engRxByte = 8'h00;

  always #2.5 clk = ~clk;

  smbus_host_seq u_dut (
    .clk(clk), .rst_n(rst_n), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .engGo(engGo),
    .engTxByte(engTxByte), .engStartCond(engStartCond),
    .engStopCond(engStopCond), .engRx(engRx), .engKill(engKill),
    .engDone(engDone), .engRxByte(engRxByte), .engNak(engNak),
    .engCollide(engCollide)
  );

  int nChk = 0, nFail = 0, cyc = 0;
  bit finished = 0;

  // engine model state
  int issued = 0, starts = 0, stops = 0, stepNum = 0, countdown = 0;
  int nakIdx = 15, colIdx = 15, engLat = 2, vecId = 0, seenVec = 0;
  logic [7:0] firstTx = 8'h00, lastTx = 8'h00;

  always @(negedge clk) begin
    if (seenVec != vecId) begin
      seenVec = vecId; issued = 0; starts = 0; stops = 0; stepNum = 0;
      countdown = 0; firstTx = 8'h00; lastTx = 8'h00;
    end
    engDone = 1'b0; engNak = 1'b0; engCollide = 1'b0;
    if (countdown > 0) begin
      countdown--;
      if (countdown == 0) begin
        engDone    = 1'b1;
        engNak     = (stepNum == nakIdx);
        engCollide = (stepNum == colIdx);
        engRxByte  = 8'h50 + 8'(stepNum);
        stepNum++;
      end
    end else if (engGo === 1'b1) begin
      if (issued == 0) firstTx = engTxByte;
      if (!engRx) lastTx = engTxByte;
      starts += int'(engStartCond);
      stops  += int'(engStopCond);
      issued++;
      countdown = engLat;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic waitIdle();
    logic [7:0] s;
    for (int k = 0; k < 500; k++) begin
      @(negedge clk);
      rd(3'd0, s);
      if (!s[0]) break;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end

  typedef struct packed {
    logic [2:0] proto;
    logic [7:0] addr, cmd, wd0, wd1;
    logic [3:0] nakAt, colAt, cnt;
    logic [7:0] first, last;
    logic [1:0] starts, stops;
    logic [7:0] st, d0, d1;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 8'hA0, 8'h00, 8'h11, 8'h22, 4'hF, 4'hF, 4'd1, 8'hA0, 8'hA0, 2'd1, 2'd1, 8'h02, 8'h11, 8'h22},
    '{3'd0, 8'hA1, 8'h00, 8'h11, 8'h22, 4'hF, 4'hF, 4'd1, 8'hA1, 8'hA1, 2'd1, 2'd1, 8'h02, 8'h11, 8'h22},
    '{3'd1, 8'h40, 8'h5A, 8'h11, 8'h22, 4'hF, 4'hF, 4'd2, 8'h40, 8'h5A, 2'd1, 2'd1, 8'h02, 8'h11, 8'h22},
    '{3'd1, 8'h41, 8'h5A, 8'h11, 8'h22, 4'hF, 4'hF, 4'd2, 8'h41, 8'h41, 2'd1, 2'd1, 8'h02, 8'h51, 8'h22},
    '{3'd2, 8'h44, 8'h10, 8'h33, 8'h22, 4'hF, 4'hF, 4'd3, 8'h44, 8'h33, 2'd1, 2'd1, 8'h02, 8'h33, 8'h22},
    '{3'd2, 8'h45, 8'h10, 8'h11, 8'h22, 4'hF, 4'hF, 4'd4, 8'h44, 8'h45, 2'd2, 2'd1, 8'h02, 8'h53, 8'h22},
    '{3'd3, 8'h60, 8'h07, 8'hCD, 8'hAB, 4'hF, 4'hF, 4'd4, 8'h60, 8'hAB, 2'd1, 2'd1, 8'h02, 8'hCD, 8'hAB},
    '{3'd3, 8'h61, 8'h08, 8'h11, 8'h22, 4'hF, 4'hF, 4'd5, 8'h60, 8'h61, 2'd2, 2'd1, 8'h02, 8'h53, 8'h54},
    '{3'd3, 8'h60, 8'h07, 8'hCD, 8'hAB, 4'd1, 4'hF, 4'd2, 8'h60, 8'h07, 2'd1, 2'd0, 8'h04, 8'hCD, 8'hAB},
    '{3'd2, 8'h45, 8'h10, 8'h11, 8'h22, 4'hF, 4'd2, 4'd3, 8'h44, 8'h45, 2'd2, 2'd0, 8'h08, 8'h11, 8'h22},
    '{3'd1, 8'h41, 8'h00, 8'h11, 8'h22, 4'd0, 4'hF, 4'd1, 8'h41, 8'h41, 2'd1, 2'd0, 8'h04, 8'h11, 8'h22},
    '{3'd1, 8'h41, 8'h00, 8'h11, 8'h22, 4'd1, 4'hF, 4'd2, 8'h41, 8'h41, 2'd1, 2'd1, 8'h04, 8'h11, 8'h22}
  };

  initial begin
    logic [7:0] r;
    logic [7:0] acc;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R11: reset state
    acc = 8'h00;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), r);
      acc = acc | r;
    end
    chk("R11 registers zero", acc, 0);
    chk("R11 no request", engGo, 0);

    // table of transfers
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string stReq;
      v = VECS[i];
      nakIdx = v.nakAt; colIdx = v.colAt; engLat = 2; vecId++;
      wr(3'd4, v.addr); wr(3'd3, v.cmd); wr(3'd5, v.wd0); wr(3'd6, v.wd1);
      wr(3'd2, {2'b01, 1'b0, v.proto, 2'b00});
      if (i == 0) begin
        rd(3'd0, r);
        chk("R2 busy one cycle after start", r[0], 1);
      end
      waitIdle();
      stReq = (v.st == 8'h02) ? "R5 status" : ((v.st == 8'h04) ? "R6 status" : "R7 status");
      rd(3'd0, r); chk(stReq, r, v.st);
      rd(3'd5, r); chk("R4 data0", r, v.d0);
      rd(3'd6, r); chk("R4 data1", r, v.d1);
      chk("R3 step count", issued, v.cnt);
      chk("R3 first byte", firstTx, v.first);
      chk("R3 last sent byte", lastTx, v.last);
      chk("R3 start conditions", starts, v.starts);
      chk("R10 stop conditions", stops, v.stops);
      wr(3'd0, 8'h1F);
      rd(3'd0, r); chk("R9 status cleared", r, 0);
    end

    // R9: write-one-to-clear per bit, busy bit write ignored
    nakIdx = 15; colIdx = 15; vecId++;
    wr(3'd4, 8'hA0); wr(3'd2, 8'h40);
    waitIdle();
    wr(3'd0, 8'h00); rd(3'd0, r); chk("R9 zero write keeps flag", r, 8'h02);
    wr(3'd0, 8'h01); rd(3'd0, r); chk("R9 bit0 write no effect", r, 8'h02);

    // R2: start ignored while done flag pending; R1 control readback
    vecId++;
    wr(3'd2, 8'hCC);
    rd(3'd0, r); chk("R2 start blocked by flag", r, 8'h02);
    repeat (6) @(negedge clk);
    chk("R2 no step when blocked", issued, 0);
    rd(3'd2, r); chk("R1 control readback start reads 0", r, 8'h8C);
    rd(3'd1, r); chk("R1 offset 1 reads 0", r, 0);
    rd(3'd7, r); chk("R1 offset 7 reads 0", r, 0);
    wr(3'd0, 8'h02); rd(3'd0, r); chk("R9 one write clears", r, 0);

    // R2: unsupported protocol field ignored
    vecId++;
    wr(3'd2, 8'h54);
    rd(3'd0, r); chk("R2 unsupported protocol not busy", r, 0);
    repeat (6) @(negedge clk);
    chk("R2 unsupported protocol no step", issued, 0);

    // R8: kill during a slow word read
    vecId++; engLat = 20;
    wr(3'd4, 8'h61); wr(3'd5, 8'h11); wr(3'd6, 8'h22);
    wr(3'd2, 8'h4C);
    repeat (3) @(negedge clk);
    rd(3'd0, r); chk("R8 busy before kill", r, 8'h01);
    wr(3'd2, 8'h0E);
    @(negedge clk);
    rd(3'd0, r); chk("R8 kill sets failed", r, 8'h10);
    chk("R8 abort output", engKill, 1);
    repeat (40) @(negedge clk);
    rd(3'd0, r); chk("R8 late response ignored status", r, 8'h10);
    rd(3'd5, r); chk("R8 late response ignored data0", r, 8'h11);
    chk("R8 no further step", issued, 1);
    wr(3'd0, 8'h1F);
    wr(3'd2, 8'h42);
    rd(3'd0, r); chk("R2 start with kill ignored", r, 0);
    wr(3'd2, 8'h00);
    chk("R8 abort released", engKill, 0);
    vecId++; engLat = 2;
    wr(3'd4, 8'hA0); wr(3'd2, 8'h40);
    waitIdle();
    rd(3'd0, r); chk("R8 start accepted after kill cleared", r, 8'h02);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end
endmodule